// File: doc/BRIEF.md
# Two-Stage Clock Divider Ratio Calculator

This unit turns a pair of frequencies into register codes for a muxed clock generator whose output path has an optional prescaler (divide by 1 to 32) followed by a main divider (divide by 1 to 4). A request carries the source frequency, the wanted output frequency and the index of the selected source. The unit finds the smallest total division ratio that does not exceed the wanted frequency. Only the source that is wired through the prescaler may use it. For that source, the total ratio is split across the two stages in fixed tiers. The unit then reports both codes and the frequency that the generator will actually produce.

Requests enter on a valid/ready pair. `in_ready` is high only while the unit is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. While a calculation runs, `in_ready` stays low, and anything presented on the input is left untouched for later. The result side has no back-pressure. `done` pulses for one cycle when the result registers change, and the results then hold until the next result is published. The arithmetic uses one shared bit-serial divider, so a result takes about two divider passes of `FW` cycles each.

Top module: `clkdiv_ratio_calc`

## Requirements
- R1: When the source frequency is nonzero and the requested frequency is larger than it, the request is replaced by the source frequency before any division.
- R2: The total ratio is the ceiling of source divided by (clamped) request; when no split applies, the main divide equals the total and the prescale equals 1.
- R3: The split is applied only when the source index equals 3 and the total exceeds 4; source 3 with a total of 1 to 4 uses the main divider alone.
- R4: In split mode, a total below 32 gives prescale = total and main = 1; a total below 64 gives main 2; a total below 96 gives main 3; a larger total gives main 4. In every case prescale = ceiling(total / main).
- R5: `main_code` = main − 1 (2 bits) and `pre_code` = prescale − 1 (5 bits), so a total of 128 on source 3 gives codes 3 and 31.
- R6: `out_freq` = floor(floor(source / prescale) / main), and it is never larger than the source frequency.
- R7: A requested frequency of zero finishes with `req_err` = 1 and `range_err` = 0, both codes 0 and `out_freq` 0.
- R8: For source indices 0 to 2, a total above 4 gives `range_err` = 1 with codes and `out_freq` forced to 0.
- R9: For source 3, a total above 128 gives `range_err` = 1 with codes and `out_freq` forced to 0.
- R10: A source frequency of zero with a nonzero request gives a total of 1: codes 0 and `out_freq` 0, with no error.
- R11: `done` is high for exactly one cycle per accepted request, `in_ready` is low from acceptance until `done`, inputs offered while busy are ignored, and the result outputs change only in a cycle where `done` is high.
- R12: After reset, `in_ready` = 1, `done` = 0, and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_src_freq | input | FW (32) | Source frequency |
| in_req_freq | input | FW (32) | Requested output frequency |
| in_src_sel | input | SW (2) | Source index; index 3 has the prescaler |
| done | output | 1 | One-cycle result strobe |
| req_err | output | 1 | Requested frequency was zero |
| range_err | output | 1 | Total ratio not reachable by the stages |
| pre_code | output | PW (5) | Prescale minus one |
| main_code | output | MW (2) | Main divide minus one |
| out_freq | output | FW (32) | Achieved output frequency |

## Verification
Two functions can fall in the same cycle. The first is publishing a result with its `done` pulse. The second is accepting the next request, because `in_ready` returns high in the very cycle `done` is high. The bench holds a second request on the input while the first is in flight. It checks that `in_ready` stays low throughout, and that the published codes belong to the first request. It then drops the second request at the `done` cycle and confirms that the outputs and `done` stay quiet afterwards, which shows that no extra request slipped in.

// File: rtl/clkdiv_ratio_pkg.sv
package clkdiv_ratio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RATIO = 2'd1,
    ST_FREQ  = 2'd2
  } calc_state_t;
endpackage

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;
  logic [W:0]    trial;
  logic [W-1:0]  diff;
  logic          ge;

  // one restoring step per cycle: shift in the next dividend bit
  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    ge    = trial >= {1'b0, dvs_q};
    diff  = trial[W-1:0] - dvs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        quo_q <= dividend;
        rem_q <= '0;
        dvs_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        quo_q <= {quo_q[W-2:0], ge};
        rem_q <= ge ? diff : trial[W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin = fin_q;
  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/ratio_split.sv
module ratio_split #(
  parameter int FW      = 32,
  parameter int SW      = 2,
  parameter int PW      = 5,
  parameter int MW      = 2,
  parameter int PRE_SRC = 3
) (
  input  logic [FW-1:0] total,
  input  logic [SW-1:0] sel,
  output logic [PW:0]   pre_val,
  output logic [MW:0]   main_val,
  output logic          range_err
);
  localparam int PRE_MAX  = 1 << PW;
  localparam int MAIN_MAX = 1 << MW;
  localparam int LIM      = PRE_MAX * MAIN_MAX;
  localparam int LW       = $clog2(LIM + 1);

  logic [LW:0] t_small;
  logic [LW:0] cand [1:MAIN_MAX];
  logic [LW:0] cand_pick;
  int          m;

  assign t_small = {1'b0, total[LW-1:0]};

  // one ceiling divider by a constant per possible main-stage value
  for (genvar k = 1; k <= MAIN_MAX; k++) begin : g_cand
    assign cand[k] = (t_small + (LW+1)'(k - 1)) / (LW+1)'(k);
  end

  always_comb begin
    range_err = 1'b0;
    pre_val   = (PW+1)'(1);
    main_val  = total[MW:0];
    m         = MAIN_MAX;
    cand_pick = cand[MAIN_MAX];
    if (total > FW'(MAIN_MAX)) begin
      if (sel != SW'(PRE_SRC)) begin
        range_err = 1'b1;
      end else if (total > FW'(LIM)) begin
        range_err = 1'b1;
      end else begin
        for (int k = MAIN_MAX - 1; k >= 1; k--) begin
          if (total < FW'(PRE_MAX * k)) m = k;
        end
        cand_pick = cand[m];
        main_val  = (MW+1)'(m);
        pre_val   = cand_pick[PW:0];
      end
    end
  end
endmodule

// File: rtl/clkdiv_ratio_calc.sv
module clkdiv_ratio_calc
  import clkdiv_ratio_pkg::*;
#(
  parameter int FW      = 32,
  parameter int SW      = 2,
  parameter int PW      = 5,
  parameter int MW      = 2,
  parameter int PRE_SRC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_src_freq,
  input  logic [FW-1:0] in_req_freq,
  input  logic [SW-1:0] in_src_sel,
  output logic          done,
  output logic          req_err,
  output logic          range_err,
  output logic [PW-1:0] pre_code,
  output logic [MW-1:0] main_code,
  output logic [FW-1:0] out_freq
);
  localparam int PDW = PW + MW + 2;

  calc_state_t   state_q;
  logic [FW-1:0] src_q;
  logic [SW-1:0] sel_q;
  logic [PW:0]   pre_q;
  logic [MW:0]   main_q;

  logic          accept, div_start, div_fin;
  logic [FW-1:0] req_clamped, div_a, div_b, div_quo, div_rem, total_c;
  logic [PW:0]   sp_pre;
  logic [MW:0]   sp_main;
  logic          sp_err;
  logic [PDW-1:0] prod;

  assign in_ready    = (state_q == ST_IDLE);
  assign accept      = in_valid && in_ready;
  assign req_clamped = (in_src_freq != '0 && in_req_freq > in_src_freq) ? in_src_freq : in_req_freq;
  assign prod        = PDW'(sp_pre) * PDW'(sp_main);

  always_comb begin
    total_c = div_quo + FW'(div_rem != '0);
    if (total_c == '0) total_c = FW'(1);
  end

  assign div_start = (accept && in_req_freq != '0) ||
                     (state_q == ST_RATIO && div_fin && !sp_err);
  assign div_a     = (state_q == ST_IDLE) ? in_src_freq : src_q;
  assign div_b     = (state_q == ST_IDLE) ? req_clamped : FW'(prod);

  iter_divider #(.W(FW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(div_a), .divisor(div_b),
    .fin(div_fin), .quo(div_quo), .rem(div_rem)
  );

  ratio_split #(.FW(FW), .SW(SW), .PW(PW), .MW(MW), .PRE_SRC(PRE_SRC)) u_split (
    .total(total_c), .sel(sel_q),
    .pre_val(sp_pre), .main_val(sp_main), .range_err(sp_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      src_q     <= '0;
      sel_q     <= '0;
      pre_q     <= '0;
      main_q    <= '0;
      done      <= 1'b0;
      req_err   <= 1'b0;
      range_err <= 1'b0;
      pre_code  <= '0;
      main_code <= '0;
      out_freq  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          if (in_req_freq == '0) begin
            done      <= 1'b1;
            req_err   <= 1'b1;
            range_err <= 1'b0;
            pre_code  <= '0;
            main_code <= '0;
            out_freq  <= '0;
          end else begin
            src_q   <= in_src_freq;
            sel_q   <= in_src_sel;
            state_q <= ST_RATIO;
          end
        end
        ST_RATIO: if (div_fin) begin
          if (sp_err) begin
            done      <= 1'b1;
            req_err   <= 1'b0;
            range_err <= 1'b1;
            pre_code  <= '0;
            main_code <= '0;
            out_freq  <= '0;
            state_q   <= ST_IDLE;
          end else begin
            pre_q   <= sp_pre;
            main_q  <= sp_main;
            state_q <= ST_FREQ;
          end
        end
        ST_FREQ: if (div_fin) begin
          done      <= 1'b1;
          req_err   <= 1'b0;
          range_err <= 1'b0;
          pre_code  <= PW'(pre_q - 1'b1);
          main_code <= MW'(main_q - 1'b1);
          out_freq  <= div_quo;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkdiv_ratio_calc_chk.sv
module clkdiv_ratio_calc_chk #(
  parameter int FW      = 32,
  parameter int SW      = 2,
  parameter int PW      = 5,
  parameter int MW      = 2,
  parameter int PRE_SRC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [FW-1:0] in_src_freq,
  input logic [FW-1:0] in_req_freq,
  input logic [SW-1:0] in_src_sel,
  input logic          done,
  input logic          req_err,
  input logic          range_err,
  input logic [PW-1:0] pre_code,
  input logic [MW-1:0] main_code,
  input logic [FW-1:0] out_freq
);
  logic [FW-1:0] cap_src;
  logic [SW-1:0] cap_sel;
  logic          ok_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_src <= '0;
      cap_sel <= '0;
    end else if (in_valid && in_ready) begin
      cap_src <= in_src_freq;
      cap_sel <= in_src_sel;
    end
  end

  assign ok_res = done && !req_err && !range_err;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_req_freq != '0) |=> !in_ready);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({req_err, range_err, pre_code, main_code, out_freq}));
  assert_zero_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_req_freq == '0) |=> (done && req_err && !range_err));
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (req_err || range_err)) |-> (pre_code == '0 && main_code == '0 && out_freq == '0));
  assert_freq_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ok_res |-> (out_freq <= cap_src));
  assert_no_prescale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_res && cap_sel != SW'(PRE_SRC)) |-> (pre_code == '0));
endmodule

bind clkdiv_ratio_calc clkdiv_ratio_calc_chk #(
  .FW(FW), .SW(SW), .PW(PW), .MW(MW), .PRE_SRC(PRE_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_src_freq(in_src_freq), .in_req_freq(in_req_freq), .in_src_sel(in_src_sel),
  .done(done), .req_err(req_err), .range_err(range_err),
  .pre_code(pre_code), .main_code(main_code), .out_freq(out_freq)
);

// File: tb/sim_clkdiv_ratio_calc.sv
`timescale 1ns/1ps
module sim_clkdiv_ratio_calc;
  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] src;
    logic [31:0] req;
    logic        rqe;
    logic        rge;
    logic [1:0]  mc;
    logic [4:0]  pc;
    logic [31:0] fr;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'd1000, 32'd300,  1'b0, 1'b0, 2'd3, 5'd0,  32'd250,  8'd2},  // R2 plain total 4
    '{2'd1, 32'd1000, 32'd5000, 1'b0, 1'b0, 2'd0, 5'd0,  32'd1000, 8'd1},  // R1 clamp
    '{2'd3, 32'd1000, 32'd300,  1'b0, 1'b0, 2'd3, 5'd0,  32'd250,  8'd3},  // R3 src3 total 4
    '{2'd3, 32'd40,   32'd10,   1'b0, 1'b0, 2'd3, 5'd0,  32'd10,   8'd3},  // R3 edge 4
    '{2'd3, 32'd50,   32'd10,   1'b0, 1'b0, 2'd0, 5'd4,  32'd10,   8'd4},  // R4 total 5
    '{2'd3, 32'd310,  32'd10,   1'b0, 1'b0, 2'd0, 5'd30, 32'd10,   8'd4},  // R4 total 31
    '{2'd3, 32'd320,  32'd10,   1'b0, 1'b0, 2'd1, 5'd15, 32'd10,   8'd4},  // R4 total 32
    '{2'd3, 32'd1000, 32'd30,   1'b0, 1'b0, 2'd1, 5'd16, 32'd29,   8'd6},  // R6 truncation
    '{2'd3, 32'd1000, 32'd15,   1'b0, 1'b0, 2'd2, 5'd22, 32'd14,   8'd6},  // R6 tier 3
    '{2'd3, 32'd950,  32'd10,   1'b0, 1'b0, 2'd2, 5'd31, 32'd9,    8'd4},  // R4 total 95
    '{2'd3, 32'd960,  32'd10,   1'b0, 1'b0, 2'd3, 5'd23, 32'd10,   8'd4},  // R4 total 96
    '{2'd3, 32'd1280, 32'd10,   1'b0, 1'b0, 2'd3, 5'd31, 32'd10,   8'd5},  // R5 total 128
    '{2'd3, 32'd1290, 32'd10,   1'b0, 1'b1, 2'd0, 5'd0,  32'd0,    8'd9},  // R9 total 129
    '{2'd0, 32'd1000, 32'd100,  1'b0, 1'b1, 2'd0, 5'd0,  32'd0,    8'd8},  // R8 total 10
    '{2'd2, 32'd0,    32'd5,    1'b0, 1'b0, 2'd0, 5'd0,  32'd0,    8'd10}, // R10 zero source
    '{2'd1, 32'd1000, 32'd0,    1'b1, 1'b0, 2'd0, 5'd0,  32'd0,    8'd7},  // R7 zero request
    '{2'd0, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b1, 2'd0, 5'd0, 32'd0,    8'd8},  // R8 huge total
    '{2'd2, 32'd1000, 32'd250,  1'b0, 1'b0, 2'd3, 5'd0,  32'd250,  8'd2},  // R2 exact 4
    '{2'd3, 32'd1000, 32'd1000, 1'b0, 1'b0, 2'd0, 5'd0,  32'd1000, 8'd5}   // R5 total 1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_src_freq = '0;
  logic [31:0] in_req_freq = '0;
  logic [1:0]  in_src_sel = '0;
  logic        done, req_err, range_err;
  logic [4:0]  pre_code;
  logic [1:0]  main_code;
  logic [31:0] out_freq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clkdiv_ratio_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_freq(in_src_freq), .in_req_freq(in_req_freq), .in_src_sel(in_src_sel),
    .done(done), .req_err(req_err), .range_err(range_err),
    .pre_code(pre_code), .main_code(main_code), .out_freq(out_freq)
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // offer one request at a negedge, drop it one cycle later, wait for done
  task automatic send(input logic [1:0] s, input logic [31:0] f, input logic [31:0] r,
                      output logic got);
    int n = 0;
    @(negedge clk);
    in_src_sel = s; in_src_freq = f; in_req_freq = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    got = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic got;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 in_ready", in_ready, 1);
    check("R12 done", done, 0);
    check("R12 outputs", {req_err, range_err, pre_code, main_code, out_freq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].sel, VECS[i].src, VECS[i].req, got);
      check($sformatf("R11 done seen vec%0d", i), got, 1);
      check($sformatf("R%0d req_err vec%0d", VECS[i].tag, i), req_err, VECS[i].rqe);
      check($sformatf("R%0d range_err vec%0d", VECS[i].tag, i), range_err, VECS[i].rge);
      check($sformatf("R%0d main_code vec%0d", VECS[i].tag, i), main_code, VECS[i].mc);
      check($sformatf("R%0d pre_code vec%0d", VECS[i].tag, i), pre_code, VECS[i].pc);
      check($sformatf("R%0d out_freq vec%0d", VECS[i].tag, i), out_freq, VECS[i].fr);
    end

    // R11: request offered while busy is ignored; done is a single pulse; results hold
    @(negedge clk);
    in_src_sel = 2'd3; in_src_freq = 32'd1000; in_req_freq = 32'd10; in_valid = 1'b1;
    @(negedge clk);
    in_src_sel = 2'd0; in_src_freq = 32'd1000; in_req_freq = 32'd100;
    check("R11 busy in_ready", in_ready, 0);
    for (int n = 0; n < 500 && !done; n++) begin
      @(negedge clk);
      if (!done) check("R11 busy in_ready", in_ready, 0);
    end
    in_valid = 1'b0;
    check("R11 first request main_code", main_code, 3);
    check("R11 first request pre_code", pre_code, 24);
    check("R11 first request out_freq", out_freq, 10);
    check("R11 first request range_err", range_err, 0);
    @(negedge clk);
    check("R11 done single pulse", done, 0);
    repeat (5) @(negedge clk);
    check("R11 ignored request left no result", {done, range_err, pre_code, main_code}, {1'b0, 1'b0, 5'd24, 2'd3});
    check("R11 idle ready", in_ready, 1);

    // R12 reset mid-calculation clears outputs
    @(negedge clk);
    in_src_sel = 2'd3; in_src_freq = 32'd1000; in_req_freq = 32'd30; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset ready", in_ready, 1);
    check("R12 reset outputs", {done, req_err, range_err, pre_code, main_code, out_freq}, 0);
    rst_n = 1'b1;
    repeat (80) @(negedge clk);
    check("R12 no stale done", done, 0);

    summary();
    $finish;
  end
endmodule